// File: doc/BRIEF.md
# Pin Integrity Fault Monitor

This block watches a power-converter controller for wiring faults on two pins: the ground pin and the combined current-sense / zero-crossing pin. It takes digitized comparator flags from the analog front end and a slow timebase tick. It produces four registered control outputs. These are a latched fault-stop, a latched controller-disable, an enable for the strong pull-up source on the sense pin, and a driver-inhibit that gates the power switch.

A floating ground shows up as current in the sense pin's ESD diode. That indication has to last without a break for a set number of ticks before the controller is stopped. A sense pin that sits at the supply rail means it is open, and that disables the controller straight away.

A zero-crossing watchdog restarts on every zero-crossing edge. When it runs out, the block does not simply resume switching. It turns on the strong pull-up and holds the driver off until the sense voltage rises past the arming level. A pin shorted to ground can never pass that test, so drive stays off. All flags are plain level or pulse signals sampled on the clock; the block has no streaming data path, so no valid/ready handshake applies.

Top module: `pin_fault_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are low after that edge.
- R2: If `esd_flag` stays high on every clock cycle across `GND_TICKS` cycles that carry `tick`, `fault_stop` is high after the edge that samples the last of those ticks, and not earlier.
- R3: Any cycle with `esd_flag` low restarts the ground persistence count, so a further full `GND_TICKS` ticks of unbroken indication are needed before `fault_stop` rises.
- R4: `rail_flag` high at a clock edge sets `ctrl_disable` after that edge.
- R5: Once set, `fault_stop` and `ctrl_disable` stay high whatever the inputs do, until `rst`.
- R6: With no `zc_edge` for `WD_TICKS` cycles carrying `tick`, `pullup_en` goes high after the edge that samples the last of those ticks.
- R7: A `zc_edge` restarts the watchdog count, and it takes priority over a `tick` in the same cycle.
- R8: While `pullup_en` is high, `zc_edge` and `tick` have no effect. Only `arm_flag` high clears `pullup_en` after that edge, and the watchdog then counts again from zero.
- R9: `drv_inhibit` equals the OR of `fault_stop`, `ctrl_disable` and `pullup_en` as they stood one clock earlier.
- R10: `arm_flag` has no effect while `pullup_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; the only way to clear latched faults |
| tick | input | 1 | One-cycle timebase pulse that advances both timers |
| esd_flag | input | 1 | Current detected in the sense-pin ESD diode (ground open) |
| rail_flag | input | 1 | Sense pin at the supply rail (pin open) |
| zc_edge | input | 1 | One-cycle pulse on a zero-crossing transition |
| arm_flag | input | 1 | Sense voltage above the arming level |
| fault_stop | output | 1 | Latched stop after a persistent ground fault |
| ctrl_disable | output | 1 | Latched disable after an open sense pin |
| pullup_en | output | 1 | Strong sense-pin pull-up enable after watchdog expiry |
| drv_inhibit | output | 1 | Driver gate-off request |

## Verification
The bench builds the block with `GND_TICKS = 5` and `WD_TICKS = 7`. At these lengths, random ticks and ground-fault bursts cross the persistence boundary many times in a few thousand cycles. That includes bursts that break one tick short. The watchdog also expires often enough that the arming release, and the case of zero-crossing edges arriving while the block waits for arming, are both reached repeatedly. The run is reset between random phases, because the rail latch would otherwise freeze the outputs for the rest of the run.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic {
    WD_COUNT   = 1'b0,
    WD_ARMWAIT = 1'b1
  } wd_state_t;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/pfm_persist.sv
module pfm_persist #(
  parameter int GND_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic esd_flag,
  output logic stop_q
);
  localparam int CW = pfm_pkg::cnt_width(GND_TICKS);
  localparam logic [CW-1:0] LAST = CW'(GND_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (!esd_flag) begin
      cnt_q <= '0;
    end else if (tick && !stop_q) begin
      if (cnt_q == LAST) begin
        stop_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  stop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_q) |-> ($past(esd_flag) && $past(tick)));
  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stop_q |=> stop_q);
  // R3
  persist_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(esd_flag) |-> (cnt_q <= CW'(1)));
endmodule

// File: rtl/pfm_rail_latch.sv
module pfm_rail_latch (
  input  logic clk,
  input  logic rst,
  input  logic rail_flag,
  output logic dis_q
);
  always_ff @(posedge clk) begin
    if (rst)            dis_q <= 1'b0;
    else if (rail_flag) dis_q <= 1'b1;
  end

  // R4
  dis_set_chk: assert property (@(posedge clk) disable iff (rst)
    rail_flag |=> dis_q);
  // R5
  dis_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dis_q |=> dis_q);
endmodule

// File: rtl/pfm_watchdog.sv
module pfm_watchdog #(
  parameter int WD_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic zc_edge,
  input  logic arm_flag,
  output logic wait_q
);
  import pfm_pkg::*;
  localparam int CW = cnt_width(WD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

  wd_state_t     st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= WD_COUNT;
      cnt_q <= '0;
    end else begin
      case (st_q)
        WD_COUNT: begin
          if (zc_edge) begin
            cnt_q <= '0;
          end else if (tick) begin
            if (cnt_q == LAST) begin
              st_q  <= WD_ARMWAIT;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        WD_ARMWAIT: begin
          if (arm_flag) begin
            st_q  <= WD_COUNT;
            cnt_q <= '0;
          end
        end
        default: st_q <= WD_COUNT;
      endcase
    end
  end

  assign wait_q = (st_q == WD_ARMWAIT);

  // R6
  expire_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_q) |-> ($past(tick) && !$past(zc_edge)));
  // R8
  release_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_q) |-> $past(arm_flag));
  // R7
  edge_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!wait_q && zc_edge) |=> (cnt_q == '0 && !wait_q));
endmodule

// File: rtl/pfm_gate.sv
module pfm_gate (
  input  logic clk,
  input  logic rst,
  input  logic stop_q,
  input  logic dis_q,
  input  logic wait_q,
  output logic inhibit_q
);
  always_ff @(posedge clk) begin
    if (rst) inhibit_q <= 1'b0;
    else     inhibit_q <= stop_q | dis_q | wait_q;
  end

  // R9
  gate_on_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_q || dis_q || wait_q) |=> inhibit_q);
  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(stop_q || dis_q || wait_q) |=> !inhibit_q);
endmodule

// File: rtl/pin_fault_monitor.sv
module pin_fault_monitor #(
  parameter int GND_TICKS = 200,
  parameter int WD_TICKS  = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic esd_flag,
  input  logic rail_flag,
  input  logic zc_edge,
  input  logic arm_flag,
  output logic fault_stop,
  output logic ctrl_disable,
  output logic pullup_en,
  output logic drv_inhibit
);
  logic stop_w, dis_w, wait_w, inh_w;

  pfm_persist #(.GND_TICKS(GND_TICKS)) u_persist (
    .clk(clk), .rst(rst), .tick(tick), .esd_flag(esd_flag), .stop_q(stop_w)
  );

  pfm_rail_latch u_rail (
    .clk(clk), .rst(rst), .rail_flag(rail_flag), .dis_q(dis_w)
  );

  pfm_watchdog #(.WD_TICKS(WD_TICKS)) u_wd (
    .clk(clk), .rst(rst), .tick(tick), .zc_edge(zc_edge),
    .arm_flag(arm_flag), .wait_q(wait_w)
  );

  pfm_gate u_gate (
    .clk(clk), .rst(rst), .stop_q(stop_w), .dis_q(dis_w),
    .wait_q(wait_w), .inhibit_q(inh_w)
  );

  assign fault_stop   = stop_w;
  assign ctrl_disable = dis_w;
  assign pullup_en    = wait_w;
  assign drv_inhibit  = inh_w;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !(fault_stop || ctrl_disable || pullup_en || drv_inhibit));
  // R10
  arm_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!pullup_en && arm_flag && !tick) |=> !pullup_en);
endmodule

// File: tb/tb_pin_fault_monitor.sv
module tb_pin_fault_monitor;
  localparam int G = 5;
  localparam int W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, esd_flag = 0, rail_flag = 0, zc_edge = 0, arm_flag = 0;
  logic fault_stop, ctrl_disable, pullup_en, drv_inhibit;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pin_fault_monitor #(.GND_TICKS(G), .WD_TICKS(W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .esd_flag(esd_flag),
    .rail_flag(rail_flag), .zc_edge(zc_edge), .arm_flag(arm_flag),
    .fault_stop(fault_stop), .ctrl_disable(ctrl_disable),
    .pullup_en(pullup_en), .drv_inhibit(drv_inhibit)
  );

  // reference model built from the requirements
  int   m_gc = 0, m_wc = 0;
  logic m_stop = 0, m_dis = 0, m_wait = 0, m_inh = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_gc <= 0; m_wc <= 0; m_stop <= 0; m_dis <= 0; m_wait <= 0; m_inh <= 0;
    end else begin
      m_inh <= m_stop | m_dis | m_wait;
      if (!esd_flag) m_gc <= 0;
      else if (tick && !m_stop) begin
        if (m_gc == G - 1) begin m_stop <= 1; m_gc <= 0; end
        else m_gc <= m_gc + 1;
      end
      if (rail_flag) m_dis <= 1;
      if (m_wait) begin
        if (arm_flag) begin m_wait <= 0; m_wc <= 0; end
      end else if (zc_edge) m_wc <= 0;
      else if (tick) begin
        if (m_wc == W - 1) begin m_wait <= 1; m_wc <= 0; end
        else m_wc <= m_wc + 1;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input logic t, input logic e, input logic r,
                      input logic z, input logic a);
    tick = t; esd_flag = e; rail_flag = r; zc_edge = z; arm_flag = a;
    @(negedge clk);
    check("R2 fault_stop", fault_stop, m_stop);
    check("R4 ctrl_disable", ctrl_disable, m_dis);
    check("R6 pullup_en", pullup_en, m_wait);
    check("R9 drv_inhibit", drv_inhibit, m_inh);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) step(0, 0, 0, 0, 0);
    rst = 0;
  endtask

  initial begin : watchdog
    #750000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic e;
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();
    // R1: reset state
    check("R1 stop", fault_stop, 1'b0);
    check("R1 disable", ctrl_disable, 1'b0);
    check("R1 pullup", pullup_en, 1'b0);
    check("R1 inhibit", drv_inhibit, 1'b0);

    // R2: exact persistence length
    for (int i = 0; i < G - 1; i++) step(1, 1, 0, 1, 0);
    check("R2 early", fault_stop, 1'b0);
    step(1, 1, 0, 1, 0);
    check("R2 set", fault_stop, 1'b1);
    step(0, 1, 0, 1, 0);
    check("R9 follows stop", drv_inhibit, 1'b1);
    // R5: sticky stop
    for (int i = 0; i < 10; i++) step(1, 0, 0, 1, 1);
    check("R5 stop held", fault_stop, 1'b1);

    // R3: break one tick short restarts count
    do_reset();
    for (int i = 0; i < G - 1; i++) step(1, 1, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    for (int i = 0; i < G - 1; i++) step(1, 1, 0, 1, 0);
    check("R3 restart", fault_stop, 1'b0);
    step(1, 1, 0, 1, 0);
    check("R3 full run", fault_stop, 1'b1);

    // R4 / R5: rail latch
    do_reset();
    step(0, 0, 1, 1, 0);
    check("R4 disable", ctrl_disable, 1'b1);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0);
    check("R5 disable held", ctrl_disable, 1'b1);

    // R7: edge beats a same-cycle tick
    do_reset();
    for (int i = 0; i < W - 1; i++) step(1, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0);
    for (int i = 0; i < W - 1; i++) step(1, 0, 0, 0, 0);
    check("R7 restart", pullup_en, 1'b0);
    step(1, 0, 0, 0, 0);
    check("R6 expire", pullup_en, 1'b1);

    // R8: grounded pin, edges do not release
    for (int i = 0; i < 20; i++) step(i % 2, 0, 0, 1, 0);
    check("R8 edges ignored", pullup_en, 1'b1);
    check("R8 inhibit held", drv_inhibit, 1'b1);
    step(0, 0, 0, 0, 1);
    check("R8 arm release", pullup_en, 1'b0);
    step(0, 0, 0, 0, 0);
    check("R9 inhibit off", drv_inhibit, 1'b0);

    // R10: arm outside wait
    do_reset();
    for (int i = 0; i < W - 1; i++) step(1, 0, 0, 0, 1);
    check("R10 arm idle", pullup_en, 1'b0);
    step(1, 0, 0, 0, 1);
    check("R10 count kept", pullup_en, 1'b1);

    // random phases
    for (int p = 0; p < 20; p++) begin
      do_reset();
      e = 0;
      for (int i = 0; i < 400; i++) begin
        if ($urandom % 9 == 0) e = ~e;
        step(($urandom % (2 + p % 3)) == 0, e, ($urandom % 500) == 0,
             ($urandom % (6 + p)) == 0, ($urandom % 5) == 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule